// File: doc/BRIEF.md
# USB Host Controller Command and Status Registers

This block holds the command register and the interrupt status register of a USB host controller, together with the small amount of control logic that sits behind them. Software reaches both registers over a simple register bus made of an address, a write strobe, write data and combinational read data. The command register carries the run/stop control, a self-clearing controller reset, two schedule-enable bits and a frame-list size field. The block turns these bits into control outputs for the schedule engine and into a mask that selects the significant bits of the frame index.

The halted flag is not a plain register bit. When run/stop is cleared, the block waits for the schedule engine to report an idle pipeline before it reports the halted state. When run/stop is set, the halted flag drops on the same edge. A controller reset clears the command fields and the status bits at once and aborts the current work. The reset bit then reads 1 until a reset-done pulse arrives from the rest of the controller. The frame-list size can only be programmed when a capability input allows it. Interrupt status bits are set by one-cycle event inputs, and software clears them by writing ones.

Top module: `usb_hc_cmdsts`

## Requirements
- R1: The command word is at address 0. Its layout is bit 0 run/stop, bit 1 controller reset, bits 3:2 frame-list size, bit 4 periodic enable and bit 5 asynchronous enable, with all other bits reading 0. After `rst` every field reads 0.
- R2: After run/stop is cleared, `halted` stays 0 for as long as `pipe_idle` is 0. It goes to 1 on the edge after the first cycle in which `pipe_idle` is 1.
- R3: `run_en` follows the run/stop bit. `halted` drops to 0 on the same edge at which a write sets run/stop. After `rst`, `halted` is 1.
- R4: While the controller reset is in progress, `ctrl_reset` and command bit 1 stay at 1 until `reset_done` is pulsed. Every command write in that period is ignored, including writes of 0 to bit 1.
- R5: A command write with bit 1 set starts a controller reset. On that edge it clears the run, enable and frame-list fields and all status bits, and it forces `halted` to 1.
- R6: A `reset_done` pulse during a controller reset clears the reset bit on the next edge and leaves `halted` at 1. A pulse outside a reset has no effect.
- R7: `fl_index_mask` has its 10, 9 or 8 low bits set for frame-list codes 00, 01 and 10 (1024, 512 and 256 entries).
- R8: The frame-list field takes written values only while `cap_prog_fl` is 1. Otherwise it keeps its value, which is 00 after reset.
- R9: A write of the reserved frame-list code 11 leaves the field unchanged.
- R10: Writing a 1 to a status bit at address 1 clears it. Writing a 0 leaves the bit unchanged.
- R11: A pulse on `irq_event[i]` sets status bit i. If the event arrives in the same cycle as a clear, the event wins. While a controller reset is in progress, events are ignored.
- R12: `periodic_en` and `async_en` show command bits 4 and 5.
- R13: The status word is at address 1. It holds the interrupt bits at [NUM_IRQ-1:0] and the halted flag at bit 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| cap_prog_fl | input | 1 | Capability: frame-list size is programmable |
| pipe_idle | input | 1 | Schedule engine has no transaction in flight |
| reset_done | input | 1 | One-cycle pulse: controller reset finished |
| irq_event | input | NUM_IRQ | One-cycle interrupt event pulses |
| run_en | output | 1 | Run/stop state to the schedule engine |
| ctrl_reset | output | 1 | Controller reset in progress; aborts work |
| periodic_en | output | 1 | Process the periodic schedule |
| async_en | output | 1 | Process the asynchronous schedule |
| halted | output | 1 | Controller is halted |
| fl_index_mask | output | IDX_W | Significant frame-index bits |

## Verification
The run/stop handshake is tested in two ways. In one case the stop is held with `pipe_idle` low for several cycles, and in the other the stop is followed by an idle pipeline, so a halt that comes too early shows up as a different result from one that never comes. Frame-list writes are repeated with the capability both off and on, and with each code including the reserved one, which separates missing write gating from a missing reserved-code filter. Status writes cover a clear of one bit, a write of all zeros, and a clear that meets an event in the same cycle. Controller reset is tested in three ways: while the controller is running, with writes issued in the middle of the reset, and with a stray `reset_done` pulse outside a reset.

// File: rtl/hcs_pkg.sv
package hcs_pkg;

    localparam int CMD_BITS = 6;
    localparam int HALT_BIT = 12;
    localparam logic [1:0] FLS_RSVD = 2'b11;

    typedef struct packed {
        logic       ase;
        logic       pse;
        logic [1:0] fls;
        logic       hc_reset;
        logic       run;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_HALTED  = 2'd0,
        ST_RUNNING = 2'd1,
        ST_DRAIN   = 2'd2,
        ST_RESET   = 2'd3
    } hc_state_e;

    // Low (idx_w - code) bits set; code 00/01/10 -> full, half, quarter list
    function automatic logic [15:0] fl_mask(input logic [1:0] code, input int idx_w);
        logic [31:0] ones;
        ones = (32'h1 << (idx_w - int'(code))) - 32'h1;
        return ones[15:0];
    endfunction

endpackage

// File: rtl/hcs_cmd_reg.sv
module hcs_cmd_reg
    import hcs_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int CMD_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cap_prog_fl,
    input  logic              in_reset,
    output cmd_t              cmd_q,
    output logic              rst_start,
    output logic              run_nxt
);

    logic wr_cmd;
    cmd_t wcmd;
    cmd_t cmd_d;

    always_comb begin
        wr_cmd    = wr && (addr == ADDR_W'(CMD_ADDR));
        wcmd      = cmd_t'(wdata[CMD_BITS-1:0]);
        rst_start = wr_cmd && wcmd.hc_reset && !in_reset;
        cmd_d     = cmd_q;
        cmd_d.hc_reset = 1'b0;
        if (in_reset || rst_start) begin
            cmd_d = '0;
        end else if (wr_cmd) begin
            cmd_d.run = wcmd.run;
            cmd_d.pse = wcmd.pse;
            cmd_d.ase = wcmd.ase;
            if (cap_prog_fl && (wcmd.fls != FLS_RSVD))
                cmd_d.fls = wcmd.fls;
        end
        run_nxt = cmd_d.run;
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_q <= '0;
        else     cmd_q <= cmd_d;
    end

    assert_fls_locked_R8: assert property (@(posedge clk) disable iff (rst)
        (!cap_prog_fl && !rst_start) |=> $stable(cmd_q.fls));

    assert_fls_rsvd_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && wcmd.fls == FLS_RSVD && !rst_start) |=> $stable(cmd_q.fls));

    assert_reset_clears_R5: assert property (@(posedge clk) disable iff (rst)
        rst_start |=> (!cmd_q.run && !cmd_q.pse && !cmd_q.ase && cmd_q.fls == 2'b00));

    assert_reset_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        in_reset |=> (!cmd_q.run && !cmd_q.pse && !cmd_q.ase));

endmodule

// File: rtl/hcs_halt_fsm.sv
module hcs_halt_fsm
    import hcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rst_start,
    input  logic run_nxt,
    input  logic reset_done,
    input  logic pipe_idle,
    output logic in_reset,
    output logic halted
);

    hc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (rst_start) begin
            state_d = ST_RESET;
        end else begin
            unique case (state_q)
                ST_RESET:   if (reset_done) state_d = ST_HALTED;
                ST_HALTED:  if (run_nxt) state_d = ST_RUNNING;
                ST_RUNNING: if (!run_nxt) state_d = ST_DRAIN;
                ST_DRAIN: begin
                    if (run_nxt)        state_d = ST_RUNNING;
                    else if (pipe_idle) state_d = ST_HALTED;
                end
                default:    state_d = ST_HALTED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HALTED;
        else     state_q <= state_d;
    end

    assign in_reset = (state_q == ST_RESET);
    assign halted   = (state_q == ST_RESET) || (state_q == ST_HALTED);

    assert_drain_waits_R2: assert property (@(posedge clk) disable iff (rst)
        (!halted && !run_nxt && !pipe_idle && !rst_start) |=> !halted);

    assert_run_unhalts_R3: assert property (@(posedge clk) disable iff (rst)
        (run_nxt && !rst_start) |=> !halted);

    assert_reset_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (in_reset && !reset_done) |=> in_reset);

    assert_reset_abort_R5: assert property (@(posedge clk) disable iff (rst)
        rst_start |=> (in_reset && halted));

    assert_reset_done_R6: assert property (@(posedge clk) disable iff (rst)
        (in_reset && reset_done) |=> (halted && !in_reset));

endmodule

// File: rtl/hcs_irq_status.sv
module hcs_irq_status #(
    parameter int NUM_IRQ = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_sts,
    input  logic [NUM_IRQ-1:0] clr_bits,
    input  logic [NUM_IRQ-1:0] irq_event,
    input  logic               clear_all,
    output logic [NUM_IRQ-1:0] sts_q
);

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clear_all)            sts_q[i] <= 1'b0;
            else if (irq_event[i])           sts_q[i] <= 1'b1;
            else if (wr_sts && clr_bits[i])  sts_q[i] <= 1'b0;
        end

        assert_event_sets_R11: assert property (@(posedge clk) disable iff (rst)
            (irq_event[i] && !clear_all) |=> sts_q[i]);

        assert_w1c_R10: assert property (@(posedge clk) disable iff (rst)
            (wr_sts && clr_bits[i] && !irq_event[i]) |=> !sts_q[i]);

        assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
            (!irq_event[i] && !(wr_sts && clr_bits[i]) && !clear_all) |=> $stable(sts_q[i]));
    end

endmodule

// File: rtl/usb_hc_cmdsts.sv
module usb_hc_cmdsts
    import hcs_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int NUM_IRQ  = 4,
    parameter int IDX_W    = 10,
    parameter int CMD_ADDR = 0,
    parameter int STS_ADDR = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic               cap_prog_fl,
    input  logic               pipe_idle,
    input  logic               reset_done,
    input  logic [NUM_IRQ-1:0] irq_event,
    output logic               run_en,
    output logic               ctrl_reset,
    output logic               periodic_en,
    output logic               async_en,
    output logic               halted,
    output logic [IDX_W-1:0]   fl_index_mask
);

    cmd_t               cmd_q;
    cmd_t               cmd_view;
    logic               rst_start;
    logic               run_nxt;
    logic               in_reset;
    logic [NUM_IRQ-1:0] sts_q;
    logic [15:0]        mask_full;

    hcs_cmd_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_ADDR(CMD_ADDR)) u_cmd (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .cap_prog_fl(cap_prog_fl), .in_reset(in_reset), .cmd_q(cmd_q),
        .rst_start(rst_start), .run_nxt(run_nxt)
    );

    hcs_halt_fsm u_fsm (
        .clk(clk), .rst(rst), .rst_start(rst_start), .run_nxt(run_nxt),
        .reset_done(reset_done), .pipe_idle(pipe_idle),
        .in_reset(in_reset), .halted(halted)
    );

    hcs_irq_status #(.NUM_IRQ(NUM_IRQ)) u_sts (
        .clk(clk), .rst(rst),
        .wr_sts(reg_wr && (reg_addr == ADDR_W'(STS_ADDR))),
        .clr_bits(reg_wdata[NUM_IRQ-1:0]), .irq_event(irq_event),
        .clear_all(rst_start || in_reset), .sts_q(sts_q)
    );

    always_comb begin
        cmd_view          = cmd_q;
        cmd_view.hc_reset = in_reset;
        mask_full         = fl_mask(cmd_q.fls, IDX_W);
        reg_rdata         = '0;
        if (reg_addr == ADDR_W'(CMD_ADDR)) begin
            reg_rdata[CMD_BITS-1:0] = cmd_view;
        end else if (reg_addr == ADDR_W'(STS_ADDR)) begin
            reg_rdata[NUM_IRQ-1:0] = sts_q;
            reg_rdata[HALT_BIT]    = halted;
        end
    end

    assign run_en        = cmd_q.run;
    assign ctrl_reset    = in_reset;
    assign periodic_en   = cmd_q.pse;
    assign async_en      = cmd_q.ase;
    assign fl_index_mask = mask_full[IDX_W-1:0];

    assert_mask_width_R7: assert property (@(posedge clk) disable iff (rst)
        ($countones(fl_index_mask) >= IDX_W - 2) && fl_index_mask[0]);

    assert_run_vs_halt_R3: assert property (@(posedge clk) disable iff (rst)
        run_en |-> !halted);

endmodule

// File: tb/sim_usb_hc_cmdsts.sv
module sim_usb_hc_cmdsts;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cap_prog_fl = 1'b0;
    logic        pipe_idle = 1'b0;
    logic        reset_done = 1'b0;
    logic [3:0]  irq_event = '0;
    logic        run_en, ctrl_reset, periodic_en, async_en, halted;
    logic [9:0]  fl_index_mask;

    int checks = 0;
    int fails  = 0;

    // reference model state
    logic       m_run = 0, m_rst = 0, m_pse = 0, m_ase = 0;
    logic [1:0] m_fls = 0;
    int         m_state = 0;   // 0 halted, 1 running, 2 draining
    logic [3:0] m_sts = 0;

    always #5 clk = ~clk;

    usb_hc_cmdsts u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_prog_fl(cap_prog_fl),
        .pipe_idle(pipe_idle), .reset_done(reset_done), .irq_event(irq_event),
        .run_en(run_en), .ctrl_reset(ctrl_reset), .periodic_en(periodic_en),
        .async_en(async_en), .halted(halted), .fl_index_mask(fl_index_mask)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic m_halted();
        return m_rst || (m_state == 0);
    endfunction

    function automatic logic [9:0] m_mask();
        case (m_fls)
            2'd0:    return 10'h3FF;
            2'd1:    return 10'h1FF;
            default: return 10'h0FF;
        endcase
    endfunction

    function automatic logic [31:0] m_rdata(input logic [3:0] a);
        logic [31:0] r;
        r = '0;
        if (a == 4'd0) r = {26'd0, m_ase, m_pse, m_fls, m_rst, m_run};
        else if (a == 4'd1) begin
            r[3:0] = m_sts;
            r[12]  = m_halted();
        end
        return r;
    endfunction

    task automatic compare();
        check(run_en == m_run, "R3 run_en", 32'(run_en), 32'(m_run));
        check(ctrl_reset == m_rst, "R4 ctrl_reset", 32'(ctrl_reset), 32'(m_rst));
        check(halted == m_halted(), "R2 halted", 32'(halted), 32'(m_halted()));
        check(periodic_en == m_pse && async_en == m_ase, "R12 enables",
              {30'd0, async_en, periodic_en}, {30'd0, m_ase, m_pse});
        check(fl_index_mask == m_mask(), "R7 mask", 32'(fl_index_mask), 32'(m_mask()));
        check(reg_rdata == m_rdata(reg_addr), (reg_addr == 0) ? "R1 cmd read" : "R13 sts read",
              reg_rdata, m_rdata(reg_addr));
    endtask

    task automatic model_step();
        logic wc, ws, run_n;
        wc = reg_wr && reg_addr == 4'd0;
        ws = reg_wr && reg_addr == 4'd1;
        if (m_rst) begin
            if (reset_done) begin m_rst = 0; m_state = 0; end
        end else if (wc && reg_wdata[1]) begin
            m_rst = 1; m_run = 0; m_pse = 0; m_ase = 0; m_fls = 0; m_sts = 0; m_state = 0;
        end else begin
            run_n = wc ? reg_wdata[0] : m_run;
            if (wc) begin
                m_pse = reg_wdata[4];
                m_ase = reg_wdata[5];
                if (cap_prog_fl && reg_wdata[3:2] != 2'b11) m_fls = reg_wdata[3:2];
            end
            if (m_state == 0 && run_n) m_state = 1;
            else if (m_state == 1 && !run_n) m_state = 2;
            else if (m_state == 2) m_state = run_n ? 1 : (pipe_idle ? 0 : 2);
            m_run = run_n;
            for (int i = 0; i < 4; i++) begin
                if (irq_event[i]) m_sts[i] = 1'b1;
                else if (ws && reg_wdata[i]) m_sts[i] = 1'b0;
            end
        end
    endtask

    // One cycle: drive at negedge, compare, advance model, wait next negedge
    task automatic cyc(input logic w, input logic [3:0] a, input logic [31:0] d,
                       input logic [3:0] ev, input logic idle, input logic done);
        reg_wr = w; reg_addr = a; reg_wdata = d;
        irq_event = ev; pipe_idle = idle; reset_done = done;
        #1;
        compare();
        model_step();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 R13: reset values on both addresses
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0);
        // R3 R12: run with both schedules on
        cyc(1, 0, 32'h31, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0);
        // R11: events set status bits
        cyc(0, 1, 0, 4'b0101, 0, 0);
        cyc(0, 1, 0, 0, 0, 0);
        // R10: clear bit 0, then a write of zeros changes nothing
        cyc(1, 1, 32'h1, 0, 0, 0);
        cyc(1, 1, 32'h0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0);
        // R11: event and clear of bit 2 in the same cycle, event wins
        cyc(1, 1, 32'h4, 4'b0100, 0, 0);
        cyc(0, 1, 0, 0, 0, 0);
        // R8: capability off, frame-list write ignored
        cyc(1, 0, 32'h35, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        // R7 R9: capability on, 512 / 256 / reserved / 1024
        cap_prog_fl = 1'b1;
        cyc(1, 0, 32'h35, 0, 0, 0);
        cyc(1, 0, 32'h39, 0, 0, 0);
        cyc(1, 0, 32'h3D, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(1, 0, 32'h31, 0, 0, 0);
        // R2: stop while pipeline busy, then idle
        cyc(1, 0, 32'h30, 0, 0, 0);
        for (int k = 0; k < 3; k++) cyc(0, 1, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 1, 0);
        cyc(0, 1, 0, 0, 1, 0);
        // R2: stop with an idle pipeline from the start
        cyc(1, 0, 32'h19, 0, 1, 0);
        cyc(1, 0, 32'h18, 0, 1, 0);
        cyc(0, 1, 0, 0, 1, 0);
        cyc(0, 1, 0, 0, 1, 0);
        // R5: controller reset while running with status pending
        cyc(1, 0, 32'h39, 4'b1010, 0, 0);
        cyc(1, 0, 32'h02, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0);
        // R4: writes during reset are ignored, events too
        cyc(1, 0, 32'h00, 0, 0, 0);
        cyc(1, 0, 32'h31, 4'b1111, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0);
        // R6: reset_done ends the reset, halted remains
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        // R6: stray reset_done outside reset has no effect
        cyc(1, 0, 32'h21, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 1, 0, 0, 0, 0);
        // R3: stop and restart during drain
        cyc(1, 0, 32'h20, 0, 0, 0);
        cyc(1, 0, 32'h21, 0, 0, 0);
        cyc(0, 1, 0, 0, 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule